// File: doc/BRIEF.md
# GPIO Bank Edge Interrupt Collector

This block watches the already-synchronised levels of one GPIO bank (up to 32 pins) and turns selected transitions into sticky pending bits. Each pin has its own trigger selection: no detection, rising, falling, or any transition. A pending bit stays set until software clears it by writing a 1 to it. It is recorded whether or not the pin is masked.

Masking uses two write-only-ones registers. A 1 written to the mask-set word masks that pin. A 1 written to the mask-release word unmasks it. A 0 in either word leaves that bit as it was. The single bank interrupt is high while any pending bit belongs to an unmasked pin. After reset every pin is masked, nothing is pending and no pin detects edges.

The register bus is a single-cycle write strobe with address and data. Read data is a combinational function of the address and the stored state.

Top module: `gpio_edge_irq_bank`

## Requirements
- R1: After reset the pending word reads 0, the mask word reads all ones, every pin's trigger field reads 0 and `irq` is low.
- R2: Pin n has a control word at byte address 0x100 + 4*n, with its trigger field in bits 4:3. Value 1 makes a low-to-high transition of the pin set pending bit n on the clock edge that samples the new level.
- R3: Trigger value 2 detects high-to-low transitions only. Trigger value 3 detects transitions in both directions.
- R4: Trigger value 0 detects nothing, so the pin's pending bit is never set.
- R5: Pending bits are sticky and read back at address 0x080, with bit n belonging to pin n.
- R6: Writing to 0x080 clears every pending bit whose data bit is 1. Bits written as 0 are left untouched.
- R7: Writing to 0x0A0 sets every mask bit whose data bit is 1 and leaves the others unchanged. The mask reads back at 0x0A0.
- R8: Writing to 0x0C0 clears every mask bit whose data bit is 1 and leaves the others unchanged. Reading 0x0C0 also returns the mask.
- R9: `irq` is high exactly when some pending bit is set whose mask bit is 0. It follows the stored state in the same cycle.
- R10: If a detected transition and a clearing write to the same pending bit fall in one cycle, the bit ends up set.
- R11: A masked pin still sets its pending bit. Unmasking it afterwards raises `irq` without a new transition.
- R12: A control word reads back only its trigger field in bits 4:3, with all other bits 0, whatever value was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | NUM_PINS | Synchronised pin levels |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq | output | 1 | Bank interrupt |

## Verification
The bench builds the block with its defaults: 32 pins, a 32-bit data word, a 12-bit address and the combinational interrupt variant. With those values the top pin shares a data word with the full mask and pending registers, and the last control word sits at the end of the control region. Sparse random pin toggles together with random trigger, mask and clear writes reach every trigger code on every pin. They also produce masked captures and clears that land in the same cycle as an edge.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;

   typedef enum logic [1:0] {
      TRIG_NONE = 2'd0,
      TRIG_RISE = 2'd1,
      TRIG_FALL = 2'd2,
      TRIG_ANY  = 2'd3
   } trig_e;

   // bit position of the trigger field inside a pin control word
   localparam int unsigned TRIG_LSB = 3;

   // byte offsets of the bank registers
   localparam int unsigned OFS_PEND  = 32'h080;
   localparam int unsigned OFS_MSET  = 32'h0A0;
   localparam int unsigned OFS_MCLR  = 32'h0C0;
   localparam int unsigned OFS_CTRL  = 32'h100;
   localparam int unsigned CTRL_STEP = 4;

endpackage

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge
   import gpio_eirq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PINS-1:0]  pin_lvl,
   input  trig_e [NUM_PINS-1:0] trig_cfg,
   input  logic [NUM_PINS-1:0]  clr_vec,
   output logic [NUM_PINS-1:0]  pend_q
);

   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] hit;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_comb begin
         unique case (trig_cfg[i])
            TRIG_RISE: hit[i] = pin_lvl[i] & ~prev_q[i];
            TRIG_FALL: hit[i] = ~pin_lvl[i] & prev_q[i];
            TRIG_ANY:  hit[i] = pin_lvl[i] ^ prev_q[i];
            default:   hit[i] = 1'b0;
         endcase
      end

      // the previous level follows the pin during reset too, so no false edge
      always_ff @(posedge clk) begin
         prev_q[i] <= pin_lvl[i];
         if (!rst_n) pend_q[i] <= 1'b0;
         else        pend_q[i] <= (pend_q[i] & ~clr_vec[i]) | hit[i];
      end

      AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         pend_q[i] && !clr_vec[i] |=> pend_q[i]); // R5
      AST_RISE_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pin_lvl[i]) && trig_cfg[i] == TRIG_RISE |=> pend_q[i]); // R2
      AST_FALL_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(pin_lvl[i]) && trig_cfg[i] == TRIG_FALL |=> pend_q[i]); // R3
      AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         trig_cfg[i] == TRIG_NONE && !pend_q[i] |=> !pend_q[i]); // R4
      AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pin_lvl[i]) && trig_cfg[i] == TRIG_ANY && clr_vec[i] |=> pend_q[i]); // R10
   end

endmodule

// File: rtl/gpio_eirq_regs.sv
module gpio_eirq_regs
   import gpio_eirq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [NUM_PINS-1:0]  pend_q,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic [NUM_PINS-1:0]  mask_q,
   output trig_e [NUM_PINS-1:0] trig_cfg,
   output logic [NUM_PINS-1:0]  clr_vec
);

   localparam int unsigned CTRL_END = OFS_CTRL + CTRL_STEP * NUM_PINS;

   logic [31:0]         a32;
   logic [31:0]         ctrl_idx;
   logic                sel_pend, sel_mset, sel_mclr, sel_ctrl;
   logic [NUM_PINS-1:0] wbits;

   assign a32      = 32'(bus_addr);
   assign sel_pend = (a32 == OFS_PEND);
   assign sel_mset = (a32 == OFS_MSET);
   assign sel_mclr = (a32 == OFS_MCLR);
   assign sel_ctrl = (a32 >= OFS_CTRL) && (a32 < CTRL_END) && (a32[1:0] == 2'b00);
   assign ctrl_idx = (a32 - OFS_CTRL) >> 2;
   assign wbits    = bus_wdata[NUM_PINS-1:0];

   assign clr_vec  = (bus_wr && sel_pend) ? wbits : '0;

   always_ff @(posedge clk) begin
      if (!rst_n)                   mask_q <= '1;
      else if (bus_wr && sel_mset) mask_q <= mask_q | wbits;
      else if (bus_wr && sel_mclr) mask_q <= mask_q & ~wbits;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n)
            trig_cfg[i] <= TRIG_NONE;
         else if (bus_wr && sel_ctrl && ctrl_idx == i)
            trig_cfg[i] <= trig_e'(bus_wdata[TRIG_LSB +: 2]);
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (sel_pend)
         bus_rdata[NUM_PINS-1:0] = pend_q;
      else if (sel_mset || sel_mclr)
         bus_rdata[NUM_PINS-1:0] = mask_q;
      else if (sel_ctrl) begin
         for (int i = 0; i < NUM_PINS; i++)
            if (ctrl_idx == i) bus_rdata[TRIG_LSB +: 2] = trig_cfg[i];
      end
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && sel_mset |=> (mask_q & $past(wbits)) == $past(wbits)); // R7
   AST_MASK_REL: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && sel_mclr |=> (mask_q & $past(wbits)) == '0); // R8
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(mask_q)); // R7

endmodule

// File: rtl/gpio_eirq_combine.sv
module gpio_eirq_combine #(
   parameter int unsigned NUM_PINS = 32,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pend_q,
   input  logic [NUM_PINS-1:0] mask_q,
   output logic                irq
);

   logic [NUM_PINS-1:0] live;
   assign live = pend_q & ~mask_q;

   if (IRQ_FLOP) begin : g_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |live;
      end
   end else begin : g_comb
      assign irq = |live;

      AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> $countones(pend_q) > 0); // R9
      AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         &mask_q |-> !irq); // R9
   end

endmodule

// File: rtl/gpio_edge_irq_bank.sv
module gpio_edge_irq_bank
   import gpio_eirq_pkg::*;
#(
   parameter int unsigned NUM_PINS = 32,
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_lvl,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq
);

   localparam longint unsigned ADDR_SPAN = longint'(1) << ADDR_W;
   localparam longint unsigned CTRL_TOP  = OFS_CTRL + CTRL_STEP * NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must lie between 1 and DATA_W");
   end
   if (DATA_W < TRIG_LSB + 2) begin : g_bad_data
      $error("DATA_W too narrow for the trigger field");
   end
   if (CTRL_TOP > ADDR_SPAN) begin : g_bad_addr
      $error("ADDR_W cannot reach every control word");
   end

   logic [NUM_PINS-1:0]  pend_q;
   logic [NUM_PINS-1:0]  mask_q;
   logic [NUM_PINS-1:0]  clr_vec;
   trig_e [NUM_PINS-1:0] trig_cfg;

   gpio_eirq_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pend_q    (pend_q),
      .bus_rdata (bus_rdata),
      .mask_q    (mask_q),
      .trig_cfg  (trig_cfg),
      .clr_vec   (clr_vec)
   );

   gpio_eirq_edge #(.NUM_PINS(NUM_PINS)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_lvl  (pin_lvl),
      .trig_cfg (trig_cfg),
      .clr_vec  (clr_vec),
      .pend_q   (pend_q)
   );

   gpio_eirq_combine #(.NUM_PINS(NUM_PINS), .IRQ_FLOP(IRQ_FLOP)) u_comb (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_q (pend_q),
      .mask_q (mask_q),
      .irq    (irq)
   );

   AST_RESET_MASKED: assert property (@(posedge clk)
      !rst_n |=> &mask_q && pend_q == '0); // R1

endmodule

// File: tb/tb_gpio_edge_irq_bank.sv
`timescale 1ns/100ps
module tb_gpio_edge_irq_bank;

   localparam int NP = 32;
   localparam int AW = 12;
   localparam int DW = 32;
   localparam logic [AW-1:0] A_PEND = 12'h080;
   localparam logic [AW-1:0] A_MSET = 12'h0A0;
   localparam logic [AW-1:0] A_MCLR = 12'h0C0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin = '0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   wire  [DW-1:0] bus_rdata;
   wire           irq;

   always #2 clk = ~clk;

   gpio_edge_irq_bank dut (
      .clk(clk), .rst_n(rst_n), .pin_lvl(pin), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   int n_cmp = 0;
   int n_bad = 0;

   logic [NP-1:0] m_pend, m_mask, m_prev;
   logic [1:0]    m_cfg [NP];

   function automatic logic [AW-1:0] ctrl_a(int n);
      return AW'(12'h100 + 4 * n);
   endfunction

   function automatic logic [NP-1:0] edges(logic [NP-1:0] now, logic [NP-1:0] was);
      logic [NP-1:0] h = '0;
      for (int i = 0; i < NP; i++) begin
         case (m_cfg[i])
            2'd1: h[i] = now[i] & ~was[i];
            2'd2: h[i] = ~now[i] & was[i];
            2'd3: h[i] = now[i] ^ was[i];
            default: h[i] = 1'b0;
         endcase
      end
      return h;
   endfunction

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(logic [NP-1:0] p, bit w, logic [AW-1:0] a, logic [DW-1:0] d);
      logic [NP-1:0] clr, np_, nm;
      @(negedge clk);
      pin = p; bus_wr = w; bus_addr = a; bus_wdata = d;
      clr = (w && a == A_PEND) ? d[NP-1:0] : '0;
      np_ = (m_pend & ~clr) | edges(p, m_prev);
      nm  = m_mask;
      if (w && a == A_MSET) nm = m_mask | d[NP-1:0];
      if (w && a == A_MCLR) nm = m_mask & ~d[NP-1:0];
      @(posedge clk);
      #0.5;
      for (int i = 0; i < NP; i++)
         if (w && a == ctrl_a(i)) m_cfg[i] = d[4:3];
      m_pend = np_; m_mask = nm; m_prev = p;
      bus_wr = 1'b0;
      chk("R9 irq", DW'(irq), DW'(|(m_pend & ~m_mask)));
   endtask

   task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
      bus_addr = a;
      #0.2;
      chk(req, bus_rdata, exp);
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      m_pend = '0; m_mask = '1; m_prev = '0;
      for (int i = 0; i < NP; i++) m_cfg[i] = 2'd0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #0.5;
      // R1 reset state
      chk("R1 irq", DW'(irq), '0);
      rd(A_PEND, 32'h0, "R1 pending");
      rd(A_MSET, 32'hFFFF_FFFF, "R1 mask");
      rd(ctrl_a(5), 32'h0, "R1 trigger");

      // trigger codes: pin0 rise, pin1 fall, pin2 any, pin3 none
      cyc('0, 1, ctrl_a(0), 32'h08);
      cyc('0, 1, ctrl_a(1), 32'h10);
      cyc('0, 1, ctrl_a(2), 32'h18);
      cyc('0, 1, ctrl_a(3), 32'h00);
      rd(ctrl_a(0), 32'h08, "R2 ctrl readback");
      rd(ctrl_a(2), 32'h18, "R3 ctrl readback");

      cyc(32'hF, 0, '0, '0);
      rd(A_PEND, 32'h5, "R2 R3 rising capture");
      chk("R11 masked capture keeps irq low", DW'(irq), '0);
      cyc(32'h0, 0, '0, '0);
      rd(A_PEND, 32'h7, "R3 falling capture");
      rd(A_PEND, 32'h7, "R4 pin3 none stays clear");

      cyc('0, 1, A_PEND, 32'h0);
      rd(A_PEND, 32'h7, "R6 zero write ignored");
      cyc('0, 1, A_PEND, 32'h2);
      rd(A_PEND, 32'h5, "R6 write one clears");

      cyc('0, 1, A_MCLR, 32'h4);
      chk("R11 unmask raises irq", DW'(irq), 32'h1);
      rd(A_MSET, 32'hFFFF_FFFB, "R8 mask after release");
      rd(A_MCLR, 32'hFFFF_FFFB, "R8 readback at release word");

      cyc('0, 1, A_MSET, 32'h0);
      rd(A_MSET, 32'hFFFF_FFFB, "R7 zero write ignored");
      cyc('0, 1, A_MSET, 32'h4);
      chk("R7 remask drops irq", DW'(irq), '0);
      rd(A_MSET, 32'hFFFF_FFFF, "R7 mask set");

      cyc('0, 1, A_PEND, 32'hFFFF_FFFF);
      rd(A_PEND, 32'h0, "R6 clear all");
      cyc(32'h1, 1, A_PEND, 32'h1);
      rd(A_PEND, 32'h1, "R10 edge beats clear");

      cyc(32'h1, 1, ctrl_a(NP - 1), 32'hFFFF_FFFF);
      rd(ctrl_a(NP - 1), 32'h18, "R12 only trigger field kept");

      for (int k = 0; k < 3000; k++) begin
         logic [NP-1:0] p;
         int op, pn;
         p  = pin ^ ($urandom & $urandom & $urandom);
         op = $urandom % 6;
         pn = $urandom % NP;
         case (op)
            1: cyc(p, 1, ctrl_a(pn), $urandom);
            2: cyc(p, 1, A_MSET, $urandom & $urandom);
            3: cyc(p, 1, A_MCLR, $urandom & $urandom);
            4: cyc(p, 1, A_PEND, $urandom & $urandom);
            default: cyc(p, 0, A_PEND, $urandom);
         endcase
         rd(A_PEND, DW'(m_pend), "R5 pending random");
         rd(A_MSET, DW'(m_mask), "R7 mask random");
         if (op == 1) rd(ctrl_a(pn), DW'({m_cfg[pn], 3'b000}), "R12 ctrl random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule